// File: doc/BRIEF.md
# Ranked Four-Way Request Encoder

This block looks at four request lines and reports which one wins as a 2-bit index together with a valid flag. The winner is not chosen by index order. A fixed ranking decides it: request 0 is strongest, request 2 comes next, then request 3, and request 1 is weakest. The ranking is a parameter, so a neighbouring block can use a different order with the same logic.

The block has no clock and no state. Each output depends only on the present request vector. When no request is raised, the valid flag is low and the index is forced to zero, so that unknown values do not spread through the logic downstream. The structure has three steps. The requests are first reordered into rank slots. Next, the first occupied slot is isolated as a one-hot vector. Finally, that slot is turned back into the request index it came from.

Top module: `prio_rank_encoder`

## Requirements
- R1: Whenever request 0 (bit 0 of `req_i`) is high, `idx_o` is 2'b00 and `hit_o` is 1, whatever the other three bits are.
- R2: When bit 2 is high and bit 0 is low, `idx_o` is 2'b10 and `hit_o` is 1, whatever bits 1 and 3 are.
- R3: When bit 3 is high and bits 0 and 2 are low, `idx_o` is 2'b11 and `hit_o` is 1, whatever bit 1 is.
- R4: When bit 1 is the only high bit, `idx_o` is 2'b01 and `hit_o` is 1.
- R5: When `req_i` is 4'b0000, `hit_o` is 0 and `idx_o` is 2'b00.
- R6: `hit_o` is 1 exactly when at least one bit of `req_i` is high.
- R7: `idx_o[1]` equals (NOT bit 0) AND (bit 2 OR bit 3) for every input pattern.
- R8: Whenever `hit_o` is 1, the bit of `req_i` selected by `idx_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | 4 | Request lines, one bit per requester |
| idx_o | output | 2 | Index of the winning request, 00 when there is none |
| hit_o | output | 1 | High when any request is present |

## Verification
The bench applies all sixteen request patterns, so every overlap between a strong and a weak request is covered. The key cases are patterns where request 1 shares the bus with a stronger request. A design that ranked by plain index would give 01 or 11 where 10 or 00 is expected. A design with request 3 ranked above request 2 would report 11 for patterns 1100 and 1110. The all-zero pattern checks that the index is driven to 00 instead of being left undefined. The single-bit patterns check that each requester can win when it is alone.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;

    // Number of requesters and index width used by default
    localparam int unsigned REQ_N = 4;
    localparam int unsigned IDX_W = 2;

    // Rank table, slot 0 = strongest; each slot holds a request index.
    // Default order: 0, 2, 3, 1 (slot 0 in the low bits).
    localparam logic [REQ_N*IDX_W-1:0] RANK_DEFAULT = {2'd1, 2'd3, 2'd2, 2'd0};

endpackage

// File: rtl/prio_slot_map.sv
module prio_slot_map #(
    parameter int unsigned                   NUM_REQ    = 4,
    parameter int unsigned                   IW         = 2,
    parameter logic [NUM_REQ*IW-1:0]         RANK_ORDER = '0
) (
    input  logic [NUM_REQ-1:0] req_i,
    output logic [NUM_REQ-1:0] slot_o
);

    // Place every request into its rank slot
    for (genvar s = 0; s < NUM_REQ; s++) begin : g_slot
        localparam int unsigned SRC = int'(RANK_ORDER[s*IW +: IW]);
        assign slot_o[s] = req_i[SRC];
    end

endmodule

// File: rtl/prio_first_hit.sv
module prio_first_hit #(
    parameter int unsigned NUM_REQ = 4
) (
    input  logic [NUM_REQ-1:0] slot_i,
    output logic [NUM_REQ-1:0] win_o
);

    // seen[s] is high when any slot stronger than s is occupied
    logic [NUM_REQ-1:0] seen;

    assign seen[0] = 1'b0;
    for (genvar s = 1; s < NUM_REQ; s++) begin : g_chain
        assign seen[s] = seen[s-1] | slot_i[s-1];
    end

    for (genvar s = 0; s < NUM_REQ; s++) begin : g_win
        assign win_o[s] = slot_i[s] & ~seen[s];
    end

endmodule

// File: rtl/prio_slot_to_code.sv
module prio_slot_to_code #(
    parameter int unsigned           NUM_REQ    = 4,
    parameter int unsigned           IW         = 2,
    parameter logic [NUM_REQ*IW-1:0] RANK_ORDER = '0
) (
    input  logic [NUM_REQ-1:0] win_i,
    output logic [IW-1:0]      idx_o
);

    // Each slot contributes its source index only when it wins
    logic [NUM_REQ-1:0][IW-1:0] part;

    for (genvar s = 0; s < NUM_REQ; s++) begin : g_part
        assign part[s] = win_i[s] ? RANK_ORDER[s*IW +: IW] : '0;
    end

    always_comb begin
        idx_o = '0;
        for (int s = 0; s < NUM_REQ; s++) begin
            idx_o = idx_o | part[s];
        end
    end

endmodule

// File: rtl/prio_rank_encoder.sv
module prio_rank_encoder
    import prio_enc_pkg::*;
#(
    parameter int unsigned                   NUM_REQ    = REQ_N,
    parameter int unsigned                   IW         = IDX_W,
    parameter logic [NUM_REQ*IW-1:0]         RANK_ORDER = RANK_DEFAULT
) (
    input  logic [NUM_REQ-1:0] req_i,
    output logic [IW-1:0]      idx_o,
    output logic               hit_o
);

    logic [NUM_REQ-1:0] slot_req;
    logic [NUM_REQ-1:0] slot_win;

    prio_slot_map #(
        .NUM_REQ    (NUM_REQ),
        .IW         (IW),
        .RANK_ORDER (RANK_ORDER)
    ) u_map (
        .req_i  (req_i),
        .slot_o (slot_req)
    );

    prio_first_hit #(
        .NUM_REQ (NUM_REQ)
    ) u_first (
        .slot_i (slot_req),
        .win_o  (slot_win)
    );

    prio_slot_to_code #(
        .NUM_REQ    (NUM_REQ),
        .IW         (IW),
        .RANK_ORDER (RANK_ORDER)
    ) u_code (
        .win_i (slot_win),
        .idx_o (idx_o)
    );

    assign hit_o = |slot_win;

endmodule

// File: rtl/prio_rank_encoder_chk.sv
module prio_rank_encoder_chk (
    input logic [3:0] req_i,
    input logic [1:0] idx_o,
    input logic       hit_o
);

    // Checks written for the default ranking 0, 2, 3, 1
    always_comb begin
        p_req0_wins_r1: assert (!req_i[0] || (idx_o == 2'b00 && hit_o))
            else $error("R1 violated");
        p_req2_next_r2: assert (!(req_i[2] && !req_i[0]) || (idx_o == 2'b10 && hit_o))
            else $error("R2 violated");
        p_req3_third_r3: assert (!(req_i[3] && !req_i[0] && !req_i[2]) || (idx_o == 2'b11 && hit_o))
            else $error("R3 violated");
        p_req1_alone_r4: assert (req_i != 4'b0010 || (idx_o == 2'b01 && hit_o))
            else $error("R4 violated");
        p_idle_zero_r5: assert (req_i != 4'b0000 || (idx_o == 2'b00 && !hit_o))
            else $error("R5 violated");
        p_hit_any_r6: assert (hit_o == ($countones(req_i) != 0))
            else $error("R6 violated");
        p_high_bit_r7: assert (idx_o[1] == (!req_i[0] && (req_i[2] || req_i[3])))
            else $error("R7 violated");
        p_idx_live_r8: assert (!hit_o || req_i[idx_o])
            else $error("R8 violated");
    end

endmodule

bind prio_rank_encoder prio_rank_encoder_chk u_chk (
    .req_i (req_i),
    .idx_o (idx_o),
    .hit_o (hit_o)
);

// File: tb/tb_prio_rank_encoder.sv
module tb_prio_rank_encoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req;
    logic [1:0] idx;
    logic       hit;

    int n_checks = 0;
    int n_errors = 0;
    bit drive_done = 1'b0;

    typedef struct {
        logic [3:0] pat;
        logic [1:0] exp_idx;
        logic       exp_hit;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    prio_rank_encoder dut (
        .req_i (req),
        .idx_o (idx),
        .hit_o (hit)
    );

    // Reference: walk the ranking list, strongest first
    function automatic item_t model(input logic [3:0] p);
        int order[4] = '{0, 2, 3, 1};
        item_t it;
        it.pat = p;
        it.exp_idx = 2'b00;
        it.exp_hit = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (p[order[k]] && !it.exp_hit) begin
                it.exp_idx = 2'(order[k]);
                it.exp_hit = 1'b1;
            end
        end
        if (p[0])                         it.tag = "R1";
        else if (p[2])                    it.tag = "R2";
        else if (p[3])                    it.tag = "R3";
        else if (p[1])                    it.tag = "R4";
        else                              it.tag = "R5";
        return it;
    endfunction

    task automatic check(input string rq, input logic [3:0] p,
                         input logic [1:0] got, input logic [1:0] want);
        n_checks++;
        if (got !== want) begin
            n_errors++;
            $display("FAIL %s req=%b actual=%b expected=%b", rq, p, got, want);
        end
    endtask

    task automatic drive(input logic [3:0] p);
        @(negedge clk);
        req = p;
        sb_q.push_back(model(p));
    endtask

    // Monitor: compare at the rising edge, half a period after driving
    initial begin
        forever begin
            @(posedge clk);
            if (sb_q.size() != 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, it.pat, idx, it.exp_idx);
                check(it.tag, it.pat, {1'b0, hit}, {1'b0, it.exp_hit});
                // R6: hit follows any request
                check("R6", it.pat, {1'b0, hit}, {1'b0, (it.pat != 4'b0000)});
                // R7: high index bit formula
                check("R7", it.pat, {1'b0, idx[1]},
                      {1'b0, (!it.pat[0] && (it.pat[2] || it.pat[3]))});
                // R8: winner is a raised request
                if (hit) check("R8", it.pat, {1'b0, it.pat[idx]}, 2'b01);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (2000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        req = 4'b0000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset/idle state, R5
        @(negedge clk);
        check("R5", req, idx, 2'b00);
        check("R5", req, {1'b0, hit}, 2'b00);
        // Exhaustive sweep
        for (int p = 0; p < 16; p++) drive(4'(p));
        // Corner patterns again: weak request 1 with stronger ones
        drive(4'b1010);
        drive(4'b0110);
        drive(4'b1100);
        drive(4'b1110);
        drive(4'b0010);
        drive(4'b0000);
        @(negedge clk);
        @(negedge clk);
        drive_done = 1'b1;
        if (sb_q.size() != 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL scoreboard left %0d items", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule